// File: doc/BRIEF.md
# Power-On Semi-Suspend Reset Sequencer

This block decides when a small processor core may start running after power comes up. While the power-good flag is low the core is held, and the rest of the chip is told to return its registers to their defaults. The oscillator and the other peripherals keep running during this time. This is a semi-suspend hold and is separate from the USB suspend state. When power-good rises, a timed hold starts and counts an external one-per-millisecond tick. The hold has two phases. The first phase lasts `GUARD_MS` ticks and nothing can cut it short. The second phase lasts `WAIT_MS` further ticks. The defaults are 1 and 95.

During the second phase, an upstream USB bus reset ends the hold at once. It also leaves a bus-reset interrupt pending. That interrupt reaches the core only after firmware has set the bus-reset enable bit (bit 0 of the interrupt-enable register at 0x20) and has switched interrupts on globally. A loss of power-good at any point restarts the whole sequence.

On release, a one-cycle start pulse tells the core to load its program counter with 0x0000 and to set both stack pointers to 0x00, with no stack push. A sticky power-on status flag (bit 4 of the processor status register) records that this reset has happened.

Top module: `pwr_hold_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `cpu_run`, `exec_start` and `bus_rst_irq` are 0.
- R2: The first hold phase begins in the cycle after `pwr_ok` is sampled high in the off state and ends on the `GUARD_MS`-th sampled tick. A bus reset sampled during this phase, including on its final tick, is ignored and latches nothing.
- R3: With no bus reset, `cpu_run` rises in the cycle after the `WAIT_MS`-th tick sampled in the second phase, so the hold lasts `GUARD_MS + WAIT_MS` ticks in total. Once high, `cpu_run` stays high while `pwr_ok` stays high.
- R4: A bus reset sampled in the second phase makes `cpu_run` high in the next cycle, even when it coincides with that phase's final tick.
- R5: `exec_start` is high for exactly one cycle, which is the first cycle in which `cpu_run` is high. This is the load of 0x0000 into the program counter and of 0x00 into both stack pointers.
- R6: Only an early release latches the pending bus-reset interrupt. `bus_rst_irq` equals pending AND `bus_rst_ie` AND `glb_ie`, and it follows the two enables in the same cycle.
- R7: The pending interrupt is cleared by an `irq_ack` sampled while `bus_rst_irq` is high. An `irq_ack` sampled while `bus_rst_irq` is low has no effect.
- R8: A low `pwr_ok` sampled in any state makes `cpu_run` 0 and `regs_clr` 1 in the next cycle, clears the pending interrupt, and restarts both phases from zero.
- R9: `por_flag` is 1 after reset and in the cycle after any low `pwr_ok`. It is cleared only by `por_clr` sampled while `cpu_run` is high. A `por_clr` during the hold is ignored.
- R10: `regs_clr` is 1 exactly in the off state, and it is never high together with `cpu_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply above threshold and oscillator stable |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| usb_bus_rst | input | 1 | Upstream USB bus reset detected |
| bus_rst_ie | input | 1 | Bus-reset interrupt enable (bit 0 of register 0x20) |
| glb_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Core acknowledges the bus-reset interrupt |
| por_clr | input | 1 | Firmware clear of the power-on status flag |
| cpu_run | output | 1 | Core may execute |
| exec_start | output | 1 | Start pulse: PC to 0x0000, stack pointers to 0x00 |
| por_flag | output | 1 | Power-on reset status bit |
| regs_clr | output | 1 | Return registers, device address and interrupt enables to defaults |
| bus_rst_irq | output | 1 | Bus-reset interrupt request to the core |

## Verification
The bound checker checks the following on every cycle:
- any power loss forces the hold;
- the start pulse occurs only on the rising edge of run, and only once;
- the interrupt is gated by its two enables;
- an acknowledge removes the request;
- the power-on flag is set;
- the register clear and run are exclusive.

A tick counter inside the checker also bounds every release: the release cannot come before the guard phase has finished, and a release before the full count must have a bus reset as its cause.

Some behaviour can only be shown by the bench's scenarios:
- the exact tick on which a timed release happens;
- that a bus reset during the guard phase leaves nothing latched;
- that an early release is the only way to create a pending interrupt;
- that an acknowledge with the request low is ignored.

// File: rtl/pwr_hold_pkg.sv
// Shared types for the power-on hold sequencer.
package pwr_hold_pkg;

    // Hold sequencer states; the order is not decoded anywhere else.
    typedef enum logic [1:0] {
        HS_OFF   = 2'd0,
        HS_GUARD = 2'd1,
        HS_WAIT  = 2'd2,
        HS_RUN   = 2'd3
    } hold_state_e;

endpackage

// File: rtl/hold_tick_counter.sv
// Millisecond tick counter for one hold phase.
// Counts sampled ticks and flags the tick that reaches `limit`.
// Assumes limit >= 1 and that the owner clears it at every phase change.
module hold_tick_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Flag the tick that completes the phase.
    always_comb begin
        last = tick && (cnt_q == limit - CNT_W'(1));
    end

    // Count ticks; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hold_fsm.sv
// Hold-phase state machine.
// Steps through off, guard, wait and run.
// A low pwr_ok has priority over every other event.
// A bus reset counts only in the wait phase.
// Assumes the tick counter supplies `last` for the current phase limit.
module hold_fsm
    import pwr_hold_pkg::*;
#(
    parameter int GUARD_MS = 1,
    parameter int WAIT_MS  = 95,
    parameter int CNT_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic             bus_rst,
    input  logic             last,
    output hold_state_e      state,
    output logic [CNT_W-1:0] limit,
    output logic             cnt_clr,
    output logic             early_rel,
    output logic             start_pulse
);

    hold_state_e state_q;
    hold_state_e state_n;
    logic        start_q;

    // Pick the tick limit of the phase in progress.
    always_comb begin
        limit = (state_q == HS_GUARD) ? CNT_W'(GUARD_MS) : CNT_W'(WAIT_MS);
    end

    // A bus reset during the wait phase ends the hold early.
    always_comb begin
        early_rel = pwr_ok && bus_rst && (state_q == HS_WAIT);
    end

    // Next-state decision.
    always_comb begin
        state_n = state_q;
        if (!pwr_ok) begin
            state_n = HS_OFF;
        end else begin
            case (state_q)
                HS_OFF:   state_n = HS_GUARD;
                HS_GUARD: if (last) state_n = HS_WAIT;
                HS_WAIT:  if (bus_rst || last) state_n = HS_RUN;
                default:  state_n = HS_RUN;
            endcase
        end
    end

    // Counter restarts on any phase change and idles outside timed phases.
    always_comb begin
        cnt_clr = (state_n != state_q) || (state_q == HS_OFF) || (state_q == HS_RUN);
    end

    // State register and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_OFF;
            start_q <= 1'b0;
        end else begin
            state_q <= state_n;
            start_q <= (state_n == HS_RUN) && (state_q != HS_RUN);
        end
    end

    assign state       = state_q;
    assign start_pulse = start_q;

endmodule

// File: rtl/bus_rst_pend.sv
// Pending bus-reset interrupt.
// Latched by an early release and gated by the two enables.
// The pending bit is dropped by an acknowledge of a visible request, or by power loss.
// Assumes early_rel is a single-cycle event from the state machine.
module bus_rst_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic early_rel,
    input  logic ie,
    input  logic gie,
    input  logic ack,
    output logic irq
);

    logic pend_q;

    // The request is visible only with both enables set.
    always_comb begin
        irq = pend_q && ie && gie;
    end

    // Pending bit: set on early release, cleared on power loss or a taken acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            pend_q <= 1'b0;
        end else if (early_rel) begin
            pend_q <= 1'b1;
        end else if (ack && irq) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/por_status.sv
// Sticky power-on status bit.
// Set by reset and by power loss; firmware may clear it only while the core runs.
module por_status (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic run,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    // Set has priority over the firmware clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok) begin
            flag_q <= 1'b1;
        end else if (clr && run) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/pwr_hold_seq.sv
// Power-on semi-suspend reset sequencer (top).
// Holds the core off through a guard phase that cannot be interrupted.
// Then holds it through a wait phase that a USB bus reset can cut short.
// Releases the core with a one-cycle start pulse.
// Assumes ms_tick is a single-cycle pulse and that all inputs are synchronous to clk.
module pwr_hold_seq #(
    parameter int GUARD_MS = 1,
    parameter int WAIT_MS  = 95
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic ms_tick,
    input  logic usb_bus_rst,
    input  logic bus_rst_ie,
    input  logic glb_ie,
    input  logic irq_ack,
    input  logic por_clr,
    output logic cpu_run,
    output logic exec_start,
    output logic por_flag,
    output logic regs_clr,
    output logic bus_rst_irq
);

    import pwr_hold_pkg::*;

    localparam int MAX_MS = (GUARD_MS > WAIT_MS) ? GUARD_MS : WAIT_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    hold_state_e      state;
    logic [CNT_W-1:0] limit;
    logic             cnt_clr;
    logic             last;
    logic             early_rel;

    // Phase tick counter.
    hold_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (ms_tick),
        .limit (limit),
        .last  (last)
    );

    // Phase sequencing.
    hold_fsm #(.GUARD_MS(GUARD_MS), .WAIT_MS(WAIT_MS), .CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok      (pwr_ok),
        .bus_rst     (usb_bus_rst),
        .last        (last),
        .state       (state),
        .limit       (limit),
        .cnt_clr     (cnt_clr),
        .early_rel   (early_rel),
        .start_pulse (exec_start)
    );

    // Pending bus-reset interrupt.
    bus_rst_pend u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .early_rel (early_rel),
        .ie        (bus_rst_ie),
        .gie       (glb_ie),
        .ack       (irq_ack),
        .irq       (bus_rst_irq)
    );

    // Power-on status bit.
    por_status u_por (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .run    (cpu_run),
        .clr    (por_clr),
        .flag   (por_flag)
    );

    // Decode the run and register-clear levels from the state.
    always_comb begin
        cpu_run  = (state == HS_RUN);
        regs_clr = (state == HS_OFF);
    end

endmodule

// File: rtl/pwr_hold_seq_chk.sv
// Protocol checker for pwr_hold_seq, bound to the top module.
// Keeps its own count of hold ticks to bound each release.
module pwr_hold_seq_chk #(
    parameter int GUARD_MS = 1,
    parameter int WAIT_MS  = 95
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic ms_tick,
    input logic usb_bus_rst,
    input logic bus_rst_ie,
    input logic glb_ie,
    input logic irq_ack,
    input logic cpu_run,
    input logic exec_start,
    input logic por_flag,
    input logic regs_clr,
    input logic bus_rst_irq
);

    localparam int TOTAL = GUARD_MS + WAIT_MS;
    localparam int TW    = $clog2(TOTAL + 2);

    logic [TW-1:0] hold_ticks;

    // Ticks sampled while held with power good; restarted in the off state.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok || regs_clr) begin
            hold_ticks <= '0;
        end else if (!cpu_run && ms_tick && (hold_ticks <= TW'(TOTAL))) begin
            hold_ticks <= hold_ticks + TW'(1);
        end
    end

    assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!cpu_run && regs_clr && !bus_rst_irq));

    assert_start_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> exec_start);

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    assert_start_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |-> cpu_run);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_irq |-> (bus_rst_ie && glb_ie));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_irq && irq_ack && pwr_ok) |=> !bus_rst_irq);

    assert_guard_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> (hold_ticks >= TW'(GUARD_MS)));

    assert_hold_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_run) |-> (hold_ticks <= TW'(TOTAL)));

    assert_early_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_run) && (hold_ticks != TW'(TOTAL))) |-> $past(usb_bus_rst));

    assert_run_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_run && pwr_ok) |=> cpu_run);

    assert_por_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> por_flag);

    assert_clr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(regs_clr && cpu_run));

endmodule

bind pwr_hold_seq pwr_hold_seq_chk #(.GUARD_MS(GUARD_MS), .WAIT_MS(WAIT_MS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok      (pwr_ok),
    .ms_tick     (ms_tick),
    .usb_bus_rst (usb_bus_rst),
    .bus_rst_ie  (bus_rst_ie),
    .glb_ie      (glb_ie),
    .irq_ack     (irq_ack),
    .cpu_run     (cpu_run),
    .exec_start  (exec_start),
    .por_flag    (por_flag),
    .regs_clr    (regs_clr),
    .bus_rst_irq (bus_rst_irq)
);

// File: tb/tb_pwr_hold_seq.sv
// Self-checking bench: directed corner cases, then seeded random stimulus.
// Checks against a cycle model built from the requirements.
module tb_pwr_hold_seq;

    localparam int GUARD_MS = 1;
    localparam int WAIT_MS  = 95;
    localparam int TOTAL    = GUARD_MS + WAIT_MS;
    localparam int CLK_NS   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic ms_tick = 1'b0;
    logic usb_bus_rst = 1'b0;
    logic bus_rst_ie = 1'b0;
    logic glb_ie = 1'b0;
    logic irq_ack = 1'b0;
    logic por_clr = 1'b0;
    logic cpu_run, exec_start, por_flag, regs_clr, bus_rst_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    pwr_hold_seq #(.GUARD_MS(GUARD_MS), .WAIT_MS(WAIT_MS)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ms_tick(ms_tick),
        .usb_bus_rst(usb_bus_rst), .bus_rst_ie(bus_rst_ie), .glb_ie(glb_ie),
        .irq_ack(irq_ack), .por_clr(por_clr), .cpu_run(cpu_run),
        .exec_start(exec_start), .por_flag(por_flag), .regs_clr(regs_clr),
        .bus_rst_irq(bus_rst_irq)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: 0 off, 1 guard, 2 wait, 3 run.
    int m_st = 0;
    int m_cnt = 0;
    bit m_pend = 1'b0;
    bit m_por = 1'b1;
    bit m_exec = 1'b0;

    function automatic bit exp_irq();
        return m_pend && bus_rst_ie && glb_ie;
    endfunction

    // Advance the model with the inputs sampled at this edge.
    always @(posedge clk) begin
        int nst;
        bit early;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pend = 1'b0; m_por = 1'b1; m_exec = 1'b0;
        end else begin
            nst = m_st;
            early = 1'b0;
            if (!pwr_ok) nst = 0;
            else if (m_st == 0) nst = 1;
            else if (m_st == 1) begin
                if (ms_tick && (m_cnt + 1 == GUARD_MS)) nst = 2;
            end else if (m_st == 2) begin
                if (usb_bus_rst) begin nst = 3; early = 1'b1; end
                else if (ms_tick && (m_cnt + 1 == WAIT_MS)) nst = 3;
            end
            if (!pwr_ok) m_pend = 1'b0;
            else if (early) m_pend = 1'b1;
            else if (irq_ack && exp_irq()) m_pend = 1'b0;
            if (!pwr_ok) m_por = 1'b1;
            else if (por_clr && m_st == 3) m_por = 1'b0;
            m_exec = (nst == 3) && (m_st != 3);
            if (nst != m_st || nst == 0 || nst == 3) m_cnt = 0;
            else if (ms_tick) m_cnt = m_cnt + 1;
            m_st = nst;
        end
    end

    // Compare every output with the model mid-cycle.
    always @(negedge clk) begin
        if (!done) begin
            chk("R3/R4/R8", "cpu_run", cpu_run, m_st == 3);
            chk("R5", "exec_start", exec_start, m_exec);
            chk("R6/R7", "bus_rst_irq", bus_rst_irq, exp_irq());
            chk("R9", "por_flag", por_flag, m_por);
            chk("R10", "regs_clr", regs_clr, m_st == 0);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic tick_n(input int n, input bit with_rst);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1; usb_bus_rst = with_rst;
            step();
            ms_tick = 1'b0; usb_bus_rst = 1'b0;
        end
    endtask

    task automatic power_cycle();
        pwr_ok = 1'b0; step();
        pwr_ok = 1'b1; step();
    endtask

    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        chk("R1", "cpu_run in reset", cpu_run, 1'b0);
        chk("R1", "exec_start in reset", exec_start, 1'b0);
        chk("R9", "por_flag in reset", por_flag, 1'b1);
        rst_n = 1'b1; pwr_ok = 1'b1; bus_rst_ie = 1'b1; glb_ie = 1'b1;
        step();
        chk("R1", "cpu_run after reset", cpu_run, 1'b0);
        chk("R10", "regs_clr leaves off state", regs_clr, 1'b0);

        // R3: timed release after exactly TOTAL ticks.
        for (int k = 1; k <= TOTAL; k++) begin
            tick_n(1, 1'b0);
            chk("R3", "cpu_run during timed hold", cpu_run, k == TOTAL);
        end
        chk("R5", "exec_start on release", exec_start, 1'b1);
        step();
        chk("R5", "exec_start one cycle", exec_start, 1'b0);
        chk("R6", "no pending after timed release", bus_rst_irq, 1'b0);

        // R8/R9: power loss while running.
        pwr_ok = 1'b0; step();
        chk("R8", "cpu_run after power loss", cpu_run, 1'b0);
        chk("R10", "regs_clr after power loss", regs_clr, 1'b1);
        chk("R9", "por_flag after power loss", por_flag, 1'b1);

        // R2: bus reset during guard phase is ignored.
        pwr_ok = 1'b1; step();
        usb_bus_rst = 1'b1; step(); usb_bus_rst = 1'b0;
        tick_n(GUARD_MS, 1'b1);
        chk("R2", "cpu_run after guard-phase bus reset", cpu_run, 1'b0);
        tick_n(WAIT_MS, 1'b0);
        chk("R2", "timed release after guard-phase bus reset", cpu_run, 1'b1);
        chk("R2", "nothing latched by guard-phase bus reset", bus_rst_irq, 1'b0);

        // R4/R6/R7: early release and interrupt gating.
        power_cycle();
        tick_n(GUARD_MS + 3, 1'b0);
        bus_rst_ie = 1'b0; usb_bus_rst = 1'b1; step(); usb_bus_rst = 1'b0;
        chk("R4", "cpu_run after early release", cpu_run, 1'b1);
        chk("R5", "exec_start after early release", exec_start, 1'b1);
        chk("R6", "irq masked by bus_rst_ie", bus_rst_irq, 1'b0);
        bus_rst_ie = 1'b1; glb_ie = 1'b0; #1;
        chk("R6", "irq masked by glb_ie", bus_rst_irq, 1'b0);
        glb_ie = 1'b1; #1;
        chk("R6", "irq raised with both enables", bus_rst_irq, 1'b1);
        glb_ie = 1'b0; irq_ack = 1'b1; step(); irq_ack = 1'b0; glb_ie = 1'b1; #1;
        chk("R7", "ack with irq low ignored", bus_rst_irq, 1'b1);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        chk("R7", "ack clears irq", bus_rst_irq, 1'b0);

        // R4: bus reset on the final wait tick still latches.
        power_cycle();
        tick_n(GUARD_MS, 1'b0);
        tick_n(WAIT_MS - 1, 1'b0);
        tick_n(1, 1'b1);
        chk("R4", "release on final tick with bus reset", cpu_run, 1'b1);
        chk("R4", "pending on coincident bus reset", bus_rst_irq, 1'b1);

        // R9: firmware clear works only while running.
        por_clr = 1'b1; step(); por_clr = 1'b0;
        chk("R9", "por_clr in run", por_flag, 1'b0);
        power_cycle();
        por_clr = 1'b1; step(); por_clr = 1'b0;
        chk("R9", "por_clr during hold ignored", por_flag, 1'b1);

        // Random phase.
        for (int i = 0; i < 8000; i++) begin
            pwr_ok      = ($urandom % 900) != 0;
            ms_tick     = ($urandom % 3) == 0;
            usb_bus_rst = ($urandom % 70) == 0;
            if (($urandom % 40) == 0) bus_rst_ie = ~bus_rst_ie;
            if (($urandom % 30) == 0) glb_ie = ~glb_ie;
            irq_ack     = ($urandom % 8) == 0;
            por_clr     = ($urandom % 25) == 0;
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule